// File: doc/BRIEF.md
# Asynchronous External Memory Controller

This block lets on-chip logic read and write 32-bit words in slow external devices such as static RAM, ROM or memory-mapped data converters. Four external regions sit next to one another in the upper address range, and each one has its own chip-select pin. Each region also has its own timing word. The timing word gives the device type and, separately for reads and for writes, how many external clock cycles the address setup, the active strobe and the hold after the strobe last.

A request is accepted only while the block is idle. The block then latches the address, the write data and the selected timing word. It runs the setup, strobe and hold phases on the external pins, and ends with a one-cycle completion pulse. A read also returns the word captured from the external data bus. A request to an address outside the four regions, or to a region whose timing word names a device type this block does not serve, completes at once with an error flag and never touches the external pins. Timing words are written through a separate configuration port.

Top module: `async_xmem_ctrl`

## Requirements
- R1: Byte-address bits 31:28 select the region: 0x8 asserts ext_ce_n[0], 0x9 asserts ext_ce_n[1], 0xA asserts ext_ce_n[2] and 0xB asserts ext_ce_n[3]. All chip selects are active low, and at most one is low at any time.
- R2: A valid access holds its chip select low for S setup cycles, then P strobe cycles, then H hold cycles. In the next cycle rsp_done is high and every chip select is high.
- R3: For a read, ext_oe_n is low exactly during the strobe cycles. The value on ext_din in the last strobe cycle appears on rsp_rdata while rsp_done is high.
- R4: For a write, ext_we_n is low exactly during the strobe cycles. ext_dout_en is high and ext_dout carries the request data in every cycle the chip select is low. ext_oe_n and ext_we_n are never low together.
- R5: Timing word layout: read hold is bits 2:0, device type is bits 7:4, read strobe is bits 13:8, read setup is bits 19:16, write strobe is bits 27:22 and write setup is bits 31:28. The write hold count is bit 3 (most significant) joined to bits 21:20. Bits 15:14 are not used.
- R6: A setup count of 0 skips the setup phase. A hold count of 0 skips the hold phase. A strobe count of 0 gives one strobe cycle.
- R7: An address whose bits 31:28 are outside 0x8..0xB gives rsp_done with rsp_err high in the cycle after acceptance. No chip select, ext_oe_n or ext_we_n goes low for it.
- R8: Device type 4'b0010 (32-bit asynchronous) is the only type served. Any other code (4'b0000 8-bit ROM, 4'b0001 16-bit ROM, 4'b0011 SDRAM, 4'b0100 burst SRAM, or other) ends the access as in R7.
- R9: ext_addr carries byte-address bits 21:2 of the request and stays stable while the chip select is low.
- R10: An access uses the timing word as it stood before its acceptance edge. A configuration write in the same cycle as acceptance, or during the access, changes only later accesses.
- R11: After reset all chip selects and strobes are high, rsp_done and rsp_err are low and req_ready is high. Every timing word resets to 0x2111_0322 (read: setup 1, strobe 3, hold 2; write: setup 2, strobe 4, hold 1; asynchronous type).
- R12: req_ready is high only while idle. A request presented while req_ready is low is ignored. rsp_done lasts exactly one cycle per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External bus clock; all phase counts are in its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Timing word write strobe |
| cfg_idx | input | 2 | Region whose timing word is written |
| cfg_wdata | input | 32 | New timing word |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address of the access |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Block idle; a request is taken on this edge |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion was an error (valid with rsp_done) |
| rsp_rdata | output | 32 | Read data (valid with rsp_done of a read) |
| ext_ce_n | output | 4 | Active-low chip selects, one per region |
| ext_oe_n | output | 1 | Active-low output enable (read strobe) |
| ext_we_n | output | 1 | Active-low write enable (write strobe) |
| ext_addr | output | 20 | External word address |
| ext_dout | output | 32 | Data driven to the external bus |
| ext_dout_en | output | 1 | Drive enable for ext_dout |
| ext_din | input | 32 | Data returned by the external bus |

## Verification
A configuration write and the acceptance of an access can fall on the same clock edge, and that includes a write to the very region being accessed. The bench provokes this by raising cfg_we together with req_valid while the block is idle. It also writes a new word in the middle of a long access. The reference model builds the expected pin sequence from the timing word held before the write, and it applies the new word only to the following access. Any phase length that follows the new word too early shows up as a per-cycle mismatch.

// File: rtl/xbus_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the asynchronous external memory controller.
// Assumes a 32-bit timing word per region with the field layout below.
package xbus_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_STROBE = 3'd2,
        PH_HOLD   = 3'd3,
        PH_DONE   = 3'd4
    } phase_t;

    // Device type codes held in bits 7:4 of a timing word
    localparam logic [3:0] DEV_ROM8    = 4'b0000;
    localparam logic [3:0] DEV_ROM16   = 4'b0001;
    localparam logic [3:0] DEV_ASYNC32 = 4'b0010;
    localparam logic [3:0] DEV_SDRAM   = 4'b0011;
    localparam logic [3:0] DEV_BSRAM   = 4'b0100;

    localparam int SETUP_W  = 4;
    localparam int STROBE_W = 6;
    localparam int HOLD_W   = 3;
    localparam int CNT_W    = STROBE_W;

    typedef struct packed {
        logic [SETUP_W-1:0]  setup;
        logic [STROBE_W-1:0] strobe;
        logic [HOLD_W-1:0]   hold;
    } timing_t;

    // Extract the phase counts for one direction from a timing word
    function automatic timing_t pick_timing(input logic [31:0] w, input logic is_wr);
        timing_t t;
        if (is_wr) begin
            t.setup  = w[31:28];
            t.strobe = w[27:22];
            t.hold   = {w[3], w[21:20]};
        end else begin
            t.setup  = w[19:16];
            t.strobe = w[13:8];
            t.hold   = w[2:0];
        end
        return t;
    endfunction

    function automatic logic [3:0] dev_type(input logic [31:0] w);
        return w[7:4];
    endfunction

endpackage

// File: rtl/xbus_cfg_bank.sv
`timescale 1ns/1ps
// Module: per-region timing word storage.
// One register per region, written through a simple write port.
// Assumes the reader samples words only at access acceptance.
module xbus_cfg_bank #(
    parameter int          NSPACE   = 4,
    parameter int          CW       = 32,
    parameter logic [31:0] RST_WORD = 32'h2111_0322,
    localparam int         SW       = $clog2(NSPACE)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [SW-1:0]              wr_idx,
    input  logic [CW-1:0]              wr_data,
    output logic [NSPACE-1:0][CW-1:0]  words
);

    for (genvar gi = 0; gi < NSPACE; gi++) begin : g_word
        // Hold the timing word of region gi
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words[gi] <= CW'(RST_WORD);
            end else if (wr_en && (wr_idx == SW'(gi))) begin
                words[gi] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/xbus_space_dec.sv
`timescale 1ns/1ps
// Module: region decoder.
// Maps the top address nibble onto NSPACE consecutive regions starting
// at BASE_NIB. Assumes BASE_NIB + NSPACE does not exceed 16.
module xbus_space_dec #(
    parameter int         NSPACE   = 4,
    parameter logic [3:0] BASE_NIB = 4'h8,
    localparam int        SW       = $clog2(NSPACE)
) (
    input  logic [3:0]        nib,
    output logic              hit,
    output logic [SW-1:0]     idx,
    output logic [NSPACE-1:0] sel
);

    logic [4:0] off;

    // Offset of the nibble from the first region
    always_comb begin
        off = {1'b0, nib} - {1'b0, BASE_NIB};
        hit = (nib >= BASE_NIB) && (off < 5'(NSPACE));
        idx = off[SW-1:0];
    end

    for (genvar gi = 0; gi < NSPACE; gi++) begin : g_sel
        assign sel[gi] = hit && (idx == SW'(gi));
    end

endmodule

// File: rtl/xbus_phase_seq.sv
`timescale 1ns/1ps
// Module: access phase sequencer.
// Latches one accepted request with its timing snapshot, then walks
// SETUP, STROBE, HOLD and DONE, driving the external pins from state.
// Assumes start is raised only while idle is high.
module xbus_phase_seq
    import xbus_pkg::*;
#(
    parameter int NSPACE = 4,
    parameter int EAW    = 20,
    parameter int DW     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_bad,
    input  logic              start_wr,
    input  logic [NSPACE-1:0] start_sel,
    input  logic [EAW-1:0]    start_ea,
    input  logic [DW-1:0]     start_wdata,
    input  timing_t           start_tim,
    input  logic [DW-1:0]     ext_din,
    output logic              idle,
    output logic [NSPACE-1:0] ext_ce_n,
    output logic              ext_oe_n,
    output logic              ext_we_n,
    output logic [EAW-1:0]    ext_addr,
    output logic [DW-1:0]     ext_dout,
    output logic              ext_dout_en,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [DW-1:0]     rsp_rdata
);

    phase_t            ph;
    logic [CNT_W-1:0]  cnt;
    logic              cnt_end;
    timing_t           tim_q;
    logic              wr_q;
    logic              err_q;
    logic [NSPACE-1:0] sel_q;
    logic [EAW-1:0]    ea_q;
    logic [DW-1:0]     wd_q;
    logic [DW-1:0]     rd_q;
    logic              active;

    // Counter preload for a strobe phase; zero is widened to one cycle
    function automatic logic [CNT_W-1:0] strobe_load(input logic [STROBE_W-1:0] s);
        return (s == '0) ? '0 : CNT_W'(s - 1'b1);
    endfunction

    assign cnt_end = (cnt == '0);

    // Latch the request and snapshot its timing at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tim_q <= '0;
            wr_q  <= 1'b0;
            sel_q <= '0;
            ea_q  <= '0;
            wd_q  <= '0;
        end else if (start) begin
            tim_q <= start_tim;
            wr_q  <= start_wr;
            sel_q <= start_sel;
            ea_q  <= start_ea;
            wd_q  <= start_wdata;
        end
    end

    // Walk the access phases and count cycles within each
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph    <= PH_IDLE;
            cnt   <= '0;
            err_q <= 1'b0;
        end else begin
            case (ph)
                PH_IDLE: begin
                    if (start) begin
                        err_q <= start_bad;
                        if (start_bad) begin
                            ph <= PH_DONE;
                        end else if (start_tim.setup != '0) begin
                            ph  <= PH_SETUP;
                            cnt <= CNT_W'(start_tim.setup - 1'b1);
                        end else begin
                            ph  <= PH_STROBE;
                            cnt <= strobe_load(start_tim.strobe);
                        end
                    end
                end
                PH_SETUP: begin
                    if (cnt_end) begin
                        ph  <= PH_STROBE;
                        cnt <= strobe_load(tim_q.strobe);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_STROBE: begin
                    if (cnt_end) begin
                        if (tim_q.hold != '0) begin
                            ph  <= PH_HOLD;
                            cnt <= CNT_W'(tim_q.hold - 1'b1);
                        end else begin
                            ph <= PH_DONE;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (cnt_end) begin
                        ph <= PH_DONE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_DONE: ph <= PH_IDLE;
                default: ph <= PH_IDLE;
            endcase
        end
    end

    // Capture the external bus at the end of the last read strobe cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if ((ph == PH_STROBE) && cnt_end && !wr_q) begin
            rd_q <= ext_din;
        end
    end

    // Decode the external pins and the response from the phase
    always_comb begin
        active      = (ph == PH_SETUP) || (ph == PH_STROBE) || (ph == PH_HOLD);
        idle        = (ph == PH_IDLE);
        ext_ce_n    = active ? ~sel_q : '1;
        ext_oe_n    = !((ph == PH_STROBE) && !wr_q);
        ext_we_n    = !((ph == PH_STROBE) && wr_q);
        ext_addr    = ea_q;
        ext_dout    = wd_q;
        ext_dout_en = active && wr_q;
        rsp_done    = (ph == PH_DONE);
        rsp_err     = (ph == PH_DONE) && err_q;
        rsp_rdata   = rd_q;
    end

    // R1
    ce_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ext_ce_n));

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ext_oe_n && !ext_we_n));

    // R4
    we_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_we_n |-> (ext_ce_n != '1));

    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active)) |-> $stable(ext_addr));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R7
    bad_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && start_bad) |=> (rsp_done && rsp_err && (ext_ce_n == '1)));

    // R10
    snap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !$past(idle)) |-> $stable(tim_q));

endmodule

// File: rtl/async_xmem_ctrl.sv
`timescale 1ns/1ps
// Module: asynchronous external memory controller, top level.
// Decodes the region, checks the device type, selects read or write
// timing from the region's word and hands the access to the sequencer.
// Assumes one outstanding request; requests are taken only when idle.
module async_xmem_ctrl
    import xbus_pkg::*;
#(
    parameter int          AW       = 32,
    parameter int          DW       = 32,
    parameter int          EAW      = 20,
    parameter int          NSPACE   = 4,
    parameter logic [3:0]  BASE_NIB = 4'h8,
    parameter logic [31:0] RST_WORD = 32'h2111_0322,
    localparam int         SW       = $clog2(NSPACE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SW-1:0]     cfg_idx,
    input  logic [31:0]       cfg_wdata,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    output logic              req_ready,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [DW-1:0]     rsp_rdata,
    output logic [NSPACE-1:0] ext_ce_n,
    output logic              ext_oe_n,
    output logic              ext_we_n,
    output logic [EAW-1:0]    ext_addr,
    output logic [DW-1:0]     ext_dout,
    output logic              ext_dout_en,
    input  logic [DW-1:0]     ext_din
);

    logic [NSPACE-1:0][31:0] words;
    logic                    dec_hit;
    logic [SW-1:0]           dec_idx;
    logic [NSPACE-1:0]       dec_sel;
    logic [31:0]             sel_word;
    logic                    type_ok;
    logic                    start;
    logic                    start_bad;
    timing_t                 start_tim;
    logic                    unused_addr;

    xbus_cfg_bank #(
        .NSPACE   (NSPACE),
        .CW       (32),
        .RST_WORD (RST_WORD)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_idx  (cfg_idx),
        .wr_data (cfg_wdata),
        .words   (words)
    );

    xbus_space_dec #(
        .NSPACE   (NSPACE),
        .BASE_NIB (BASE_NIB)
    ) u_dec (
        .nib (req_addr[AW-1 -: 4]),
        .hit (dec_hit),
        .idx (dec_idx),
        .sel (dec_sel)
    );

    // Select the region word and qualify the request
    always_comb begin
        sel_word  = words[dec_idx];
        type_ok   = (dev_type(sel_word) == DEV_ASYNC32);
        start     = req_valid && req_ready;
        start_bad = !dec_hit || !type_ok;
        start_tim = pick_timing(sel_word, req_write);
    end

    assign unused_addr = ^{req_addr[AW-5:EAW+2], req_addr[1:0]};

    xbus_phase_seq #(
        .NSPACE (NSPACE),
        .EAW    (EAW),
        .DW     (DW)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .start_bad   (start_bad),
        .start_wr    (req_write),
        .start_sel   (dec_sel),
        .start_ea    (req_addr[EAW+1:2]),
        .start_wdata (req_wdata),
        .start_tim   (start_tim),
        .ext_din     (ext_din),
        .idle        (req_ready),
        .ext_ce_n    (ext_ce_n),
        .ext_oe_n    (ext_oe_n),
        .ext_we_n    (ext_we_n),
        .ext_addr    (ext_addr),
        .ext_dout    (ext_dout),
        .ext_dout_en (ext_dout_en),
        .rsp_done    (rsp_done),
        .rsp_err     (rsp_err),
        .rsp_rdata   (rsp_rdata)
    );

    // R8
    type_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && dec_hit && !type_ok) |=> (rsp_done && rsp_err));

endmodule

// File: tb/async_xmem_ctrl_bench.sv
`timescale 1ns/1ps
module async_xmem_ctrl_bench;

    typedef struct packed {
        logic [3:0] ce_n;
        logic       oe_n;
        logic       we_n;
        logic       done;
        logic       err;
        logic       rd_last;
        logic       chk_rd;
        logic       wr;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready;
    logic        rsp_done;
    logic        rsp_err;
    logic [31:0] rsp_rdata;
    logic [3:0]  ext_ce_n;
    logic        ext_oe_n;
    logic        ext_we_n;
    logic [19:0] ext_addr;
    logic [31:0] ext_dout;
    logic        ext_dout_en;
    logic [31:0] ext_din = 32'h1357_9BDF;

    int          n_checks = 0;
    int          n_fail = 0;
    bit          run = 1'b0;
    bit          finished = 1'b0;
    string       cur_case = "R11 reset";
    exp_t        exp_q[$];
    logic [31:0] cfg_m[4];
    logic [19:0] cur_ea;
    logic [31:0] cur_wd;
    logic [31:0] cap_rd;

    async_xmem_ctrl u_async_xmem_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .ext_ce_n(ext_ce_n), .ext_oe_n(ext_oe_n), .ext_we_n(ext_we_n),
        .ext_addr(ext_addr), .ext_dout(ext_dout), .ext_dout_en(ext_dout_en),
        .ext_din(ext_din)
    );

    always #2.5 clk = ~clk;

    // External bus data changes just after every rising edge
    initial forever begin
        @(posedge clk);
        #1 ext_din = ext_din + 32'h0101_0101;
    end

    // Timing word built from the R5 field positions
    function automatic logic [31:0] mk(int ws, int wst, int wh, int rs, int rst, int rh, int ty);
        logic [31:0] w = '0;
        w[31:28] = ws[3:0];
        w[27:22] = wst[5:0];
        w[21:20] = wh[1:0];
        w[3]     = wh[2];
        w[19:16] = rs[3:0];
        w[13:8]  = rst[5:0];
        w[7:4]   = ty[3:0];
        w[2:0]   = rh[2:0];
        return w;
    endfunction

    function automatic exp_t ent(logic [3:0] ce, logic oe, logic we, logic dn,
                                 logic er, logic rl, logic cr, logic wr);
        exp_t e;
        e.ce_n = ce; e.oe_n = oe; e.we_n = we; e.done = dn;
        e.err = er; e.rd_last = rl; e.chk_rd = cr; e.wr = wr;
        return e;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s case=[%s] act=%h exp=%h t=%0t", tag, cur_case, act, exp, $time);
        end
    endtask

    // Push the expected per-cycle pin values of one access (R1,R2,R6,R7,R8)
    task automatic build(input logic wr, input logic [31:0] a, input logic [31:0] wd);
        int nib = int'(a[31:28]);
        int s, p, h;
        logic [31:0] w;
        logic [3:0] cen;
        if (nib < 8 || nib > 11) begin
            exp_q.push_back(ent(4'hF, 1, 1, 1, 1, 0, 0, 0));
            return;
        end
        w = cfg_m[nib-8];
        if (w[7:4] != 4'b0010) begin
            exp_q.push_back(ent(4'hF, 1, 1, 1, 1, 0, 0, 0));
            return;
        end
        cen = ~(4'b0001 << (nib - 8));
        if (wr) begin
            s = int'(w[31:28]); p = int'(w[27:22]); h = int'({w[3], w[21:20]});
        end else begin
            s = int'(w[19:16]); p = int'(w[13:8]); h = int'(w[2:0]);
        end
        if (p == 0) p = 1;
        cur_ea = a[21:2];
        cur_wd = wd;
        for (int i = 0; i < s; i++) exp_q.push_back(ent(cen, 1, 1, 0, 0, 0, 0, wr));
        for (int i = 0; i < p; i++)
            exp_q.push_back(ent(cen, wr, !wr, 0, 0, (!wr && i == p-1), 0, wr));
        for (int i = 0; i < h; i++) exp_q.push_back(ent(cen, 1, 1, 0, 0, 0, 0, wr));
        exp_q.push_back(ent(4'hF, 1, 1, 1, 0, 0, !wr, 0));
    endtask

    // Compare the pins with the model once per cycle, mid-cycle
    task automatic compare();
        exp_t e;
        logic busy;
        busy = (exp_q.size() != 0);
        if (busy) e = exp_q.pop_front();
        else e = ent(4'hF, 1, 1, 0, 0, 0, 0, 0);
        chk("R1/R2 ce_n", 32'(ext_ce_n), 32'(e.ce_n));
        chk("R3 oe_n", 32'(ext_oe_n), 32'(e.oe_n));
        chk("R4 we_n", 32'(ext_we_n), 32'(e.we_n));
        chk("R12 done", 32'(rsp_done), 32'(e.done));
        chk("R7 err", 32'(rsp_err), 32'(e.err));
        chk("R12 ready", 32'(req_ready), 32'(!busy));
        chk("R4 dout_en", 32'(ext_dout_en), 32'(e.wr && (e.ce_n != 4'hF)));
        if (e.ce_n != 4'hF) begin
            chk("R9 addr", 32'(ext_addr), 32'(cur_ea));
            if (e.wr) chk("R4 dout", ext_dout, cur_wd);
        end
        if (e.rd_last) cap_rd = ext_din;
        if (e.chk_rd) chk("R3 rdata", rsp_rdata, cap_rd);
    endtask

    always @(negedge clk) if (run) compare();

    task automatic wait_idle();
        do begin
            @(negedge clk); #1;
        end while (exp_q.size() != 0);
        @(negedge clk); #1;
    endtask

    task automatic cfg_write(input logic [1:0] i, input logic [31:0] w);
        @(negedge clk); #1;
        cfg_we = 1; cfg_idx = i; cfg_wdata = w;
        cfg_m[i] = w;
        @(posedge clk); #1;
        cfg_we = 0;
    endtask

    task automatic access(input logic wr, input logic [31:0] a, input logic [31:0] wd,
                          input logic with_cfg, input logic [1:0] ci, input logic [31:0] cw);
        wait_idle();
        build(wr, a, wd);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd;
        if (with_cfg) begin
            cfg_we = 1; cfg_idx = ci; cfg_wdata = cw;
            cfg_m[ci] = cw;
        end
        @(posedge clk); #1;
        req_valid = 0; cfg_we = 0;
    endtask

    initial begin
        for (int i = 0; i < 4; i++) cfg_m[i] = 32'h2111_0322;
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        run = 1;
        // R11: idle pins after reset are checked by the per-cycle compare
        repeat (3) @(negedge clk);

        cur_case = "R11 default word read CE0";
        access(0, 32'h8000_0010, 0, 0, 0, 0);
        cur_case = "R11 default word write CE1";
        access(1, 32'h9012_3454, 32'hDEAD_BEEF, 0, 0, 0);

        cur_case = "R6 zero counts";
        cfg_write(2, mk(0, 0, 0, 0, 0, 0, 2));
        access(0, 32'hA03F_FFFC, 0, 0, 0, 0);
        access(1, 32'hA000_0008, 32'h0BAD_F00D, 0, 0, 0);

        cur_case = "R5 long counts and split write hold";
        cfg_write(3, mk(15, 63, 7, 15, 63, 7, 2));
        access(1, 32'hB000_0100, 32'h1234_5678, 0, 0, 0);
        access(0, 32'hB020_0200, 0, 0, 0, 0);
        cfg_write(1, mk(1, 2, 4, 2, 1, 0, 2));
        access(1, 32'h9000_0004, 32'hCAFE_0001, 0, 0, 0);

        cur_case = "R7 outside regions";
        access(0, 32'h4000_0000, 0, 0, 0, 0);
        access(1, 32'hC000_0000, 32'h1, 0, 0, 0);
        access(0, 32'h7FFF_FFFC, 0, 0, 0, 0);

        cur_case = "R8 unserved device type";
        cfg_write(1, mk(1, 1, 1, 1, 1, 1, 0));
        access(0, 32'h9000_0000, 0, 0, 0, 0);
        cfg_write(1, mk(1, 1, 1, 1, 1, 1, 3));
        access(1, 32'h9000_0000, 32'h5, 0, 0, 0);
        cfg_write(1, mk(1, 1, 1, 1, 1, 1, 2));
        access(0, 32'h9000_0040, 0, 0, 0, 0);

        cur_case = "R10 word rewritten during access";
        access(0, 32'hB000_0000, 0, 0, 0, 0);
        repeat (5) @(negedge clk);
        cfg_write(3, mk(1, 1, 1, 0, 2, 1, 2));
        access(0, 32'hB000_0004, 0, 0, 0, 0);

        cur_case = "R10 word written on acceptance edge";
        access(0, 32'hA000_0010, 0, 1, 2, mk(3, 5, 2, 4, 6, 3, 2));
        access(0, 32'hA000_0014, 0, 0, 0, 0);
        access(1, 32'hA000_0018, 32'h7777_8888, 0, 0, 0);

        cur_case = "R12 request while busy ignored";
        access(0, 32'hA000_0020, 0, 0, 0, 0);
        @(negedge clk); #1;
        req_valid = 1; req_write = 1; req_addr = 32'h8000_0000; req_wdata = 32'hFFFF_FFFF;
        @(posedge clk); #1;
        req_valid = 0;

        cur_case = "R2 back-to-back mixed";
        access(1, 32'h8000_0ABC, 32'h0F0F_0F0F, 0, 0, 0);
        access(0, 32'h8000_0ABC, 0, 0, 0, 0);
        wait_idle();
        repeat (3) @(negedge clk);
        #1;
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL R12 watchdog case=[%s] act=running exp=finished", cur_case);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule